// File: doc/BRIEF.md
# Prefetching Read Bridge with Retry

This block couples a fast upstream requester to a slower downstream burst bus. Upstream single-word reads that miss are not stalled. The bridge answers such a read with a retry status in the next cycle. It then fetches the whole aligned line around the address in one downstream burst. The requester repeats the read. Once the line is complete, the repeated read is answered with data from the bridge's one-line buffer, and no downstream traffic takes place.

Upstream writes pass the bridge for coherence only. A write that lands inside the buffered line makes that line invalid, so the bridge never returns stale data. A write is acknowledged with the done status. The downstream side is a burst master. It has one address phase with a valid/ready handshake, followed by a fixed number of data beats that carry their own valid/ready pair and an error flag. If any beat reports an error, the line is poisoned. The next read of that line reports the error once, and the read after that fetches the line again.

Top module: `prefetch_read_bridge`

## Requirements
- R1: After reset, no response is pending, no downstream request is raised and `up_ready` is high. The buffer is empty, so the first read is a miss.
- R2: A read that misses and finds no burst in flight gets the retry status and starts exactly one downstream burst for its line.
- R3: Every accepted request gets exactly one response, with `rsp_valid` high in the cycle after acceptance. The status codes are 0 for done/data, 1 for retry and 2 for error. When no request was accepted, `rsp_valid` is low in the next cycle.
- R4: A burst makes one address phase. Its address is aligned to 32 bytes (8 words of 32 bits) and is held stable until `dn_aready`. The address phase is followed by exactly 8 data beats, and beat i is stored as the word at base + 4i. Idle cycles between beats are tolerated.
- R5: A read to the line being filled gets the retry status until the last beat has been taken. It never gets partial data and never starts a second burst.
- R6: A read to a complete line gets the done status and the word selected by address bits [4:2]. Bits [1:0] are ignored. No downstream address phase occurs.
- R7: A read that misses while a burst for another line is in flight gets retry and starts no burst. After that burst ends, a repeated read of the missed address starts its own burst.
- R8: A write inside the buffered line invalidates it, so the next read of that line misses and fetches again. A write during the fill causes the fetched line to be discarded. A write outside the line has no effect. Every write gets the done status.
- R9: An error on any beat does not shorten the burst. The next read of that line gets the error status once, and the read after that misses and fetches again.
- R10: The buffer holds one line. A fetch for a new line replaces the old one, and a read of the old line then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request ready (always able to accept) |
| up_write | input | 1 | Request is a write (1) or a read (0) |
| up_addr | input | 32 | Byte address of the request |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_status | output | 2 | 0 done/data, 1 retry, 2 error |
| rsp_data | output | 32 | Read data when the status is done |
| dn_avalid | output | 1 | Downstream address phase valid |
| dn_aready | input | 1 | Downstream address phase accepted |
| dn_addr | output | 32 | Line-aligned burst start address |
| dn_dvalid | input | 1 | Downstream data beat valid |
| dn_dready | output | 1 | Bridge ready to take a data beat |
| dn_data | input | 32 | Downstream data beat |
| dn_err | input | 1 | Error flag for the current data beat |

## Verification
The embedded properties watch on every cycle that the burst address is line-aligned and held until it is accepted, and that each accepted request is answered in the next cycle. They also check that reads to a filling line get retry, that a poisoned line reports an error, and that a write hit on a complete line empties it. Only the directed scenarios can show that the returned words match the downstream data at the right offsets, and that hits cause no downstream traffic. The same holds for a miss during another fill, which must not start a burst, for a write during a fill, which must discard the line, and for the error-then-refetch sequence, which needs a later burst.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int unsigned PFB_ADDR_W     = 32;
    localparam int unsigned PFB_DATA_W     = 32;
    localparam int unsigned PFB_LINE_WORDS = 8;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_RETRY = 2'd1,
        RSP_ERROR = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        LN_EMPTY,
        LN_FILL,
        LN_READY,
        LN_FAIL
    } line_state_e;

    typedef enum logic [1:0] {
        BM_IDLE,
        BM_ADDR,
        BM_DATA
    } burst_state_e;

    typedef struct packed {
        logic      valid;
        rsp_code_e code;
    } rsp_head_t;

    function automatic rsp_code_e hit_code(line_state_e st);
        case (st)
            LN_READY: return RSP_DATA;
            LN_FAIL:  return RSP_ERROR;
            default:  return RSP_RETRY;
        endcase
    endfunction

endpackage

// File: rtl/pfb_line_store.sv
module pfb_line_store #(
    parameter int unsigned DATA_W     = pfb_pkg::PFB_DATA_W,
    parameter int unsigned LINE_WORDS = pfb_pkg::PFB_LINE_WORDS,
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [LINE_WORDS];

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(w)) begin
                words[w] <= wdata;
            end
        end
    end

    assign rdata = words[ridx];
endmodule

// File: rtl/pfb_burst_master.sv
module pfb_burst_master
    import pfb_pkg::*;
#(
    parameter int unsigned ADDR_W     = PFB_ADDR_W,
    parameter int unsigned DATA_W     = PFB_DATA_W,
    parameter int unsigned LINE_WORDS = PFB_LINE_WORDS,
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS),
    localparam int unsigned OFF_W     = IDX_W + $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    output logic              dn_avalid,
    input  logic              dn_aready,
    output logic [ADDR_W-1:0] dn_addr,
    input  logic              dn_dvalid,
    output logic              dn_dready,
    input  logic [DATA_W-1:0] dn_data,
    input  logic              dn_err,
    output logic              beat_we,
    output logic [IDX_W-1:0]  beat_idx,
    output logic [DATA_W-1:0] beat_data,
    output logic              done,
    output logic              done_err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

    burst_state_e      st_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              err_q;

    assign dn_avalid = (st_q == BM_ADDR);
    assign dn_addr   = base_q;
    assign dn_dready = (st_q == BM_DATA);
    assign beat_we   = dn_dready && dn_dvalid;
    assign beat_idx  = cnt_q;
    assign beat_data = dn_data;
    assign done      = beat_we && (cnt_q == LAST_IDX);
    assign done_err  = err_q || dn_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BM_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                BM_IDLE: if (start) begin
                    st_q   <= BM_ADDR;
                    base_q <= {start_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                    cnt_q  <= '0;
                    err_q  <= 1'b0;
                end
                BM_ADDR: if (dn_aready) st_q <= BM_DATA;
                BM_DATA: if (beat_we) begin
                    cnt_q <= cnt_q + 1'b1;
                    err_q <= err_q || dn_err;
                    if (cnt_q == LAST_IDX) st_q <= BM_IDLE;
                end
                default: st_q <= BM_IDLE;
            endcase
        end
    end

    // R4: burst address is line aligned
    p_addr_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        dn_avalid |-> (dn_addr[OFF_W-1:0] == '0));

    // R4: address phase held until accepted
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (dn_avalid && !dn_aready) |=> (dn_avalid && $stable(dn_addr)));
endmodule

// File: rtl/prefetch_read_bridge.sv
module prefetch_read_bridge
    import pfb_pkg::*;
#(
    parameter int unsigned ADDR_W     = PFB_ADDR_W,
    parameter int unsigned DATA_W     = PFB_DATA_W,
    parameter int unsigned LINE_WORDS = PFB_LINE_WORDS,
    localparam int unsigned IDX_W     = $clog2(LINE_WORDS),
    localparam int unsigned BYTE_W    = $clog2(DATA_W / 8),
    localparam int unsigned OFF_W     = IDX_W + BYTE_W,
    localparam int unsigned TAG_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_data,
    output logic              dn_avalid,
    input  logic              dn_aready,
    output logic [ADDR_W-1:0] dn_addr,
    input  logic              dn_dvalid,
    output logic              dn_dready,
    input  logic [DATA_W-1:0] dn_data,
    input  logic              dn_err
);
    line_state_e       ln_q;
    logic [TAG_W-1:0]  tag_q;
    logic              kill_q;
    rsp_head_t         rsp_q;
    logic [DATA_W-1:0] rdata_q;

    logic              rd_req, wr_req, tag_hit, launch;
    logic              beat_we, done, done_err;
    logic [IDX_W-1:0]  beat_idx;
    logic [DATA_W-1:0] beat_data, store_rd;

    assign up_ready = 1'b1;
    assign rd_req   = up_valid && !up_write;
    assign wr_req   = up_valid && up_write;
    assign tag_hit  = (ln_q != LN_EMPTY) && (up_addr[ADDR_W-1:OFF_W] == tag_q);
    assign launch   = rd_req && !tag_hit && (ln_q != LN_FILL);

    pfb_burst_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
    ) u_burst (
        .clk(clk), .rst(rst), .start(launch), .start_base(up_addr),
        .dn_avalid(dn_avalid), .dn_aready(dn_aready), .dn_addr(dn_addr),
        .dn_dvalid(dn_dvalid), .dn_dready(dn_dready), .dn_data(dn_data),
        .dn_err(dn_err), .beat_we(beat_we), .beat_idx(beat_idx),
        .beat_data(beat_data), .done(done), .done_err(done_err)
    );

    pfb_line_store #(
        .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)
    ) u_store (
        .clk(clk), .we(beat_we), .widx(beat_idx), .wdata(beat_data),
        .ridx(up_addr[OFF_W-1:BYTE_W]), .rdata(store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q    <= LN_EMPTY;
            tag_q   <= '0;
            kill_q  <= 1'b0;
            rsp_q   <= '{valid: 1'b0, code: RSP_DATA};
            rdata_q <= '0;
        end else begin
            rsp_q.valid <= up_valid;
            if (up_valid) begin
                rsp_q.code <= wr_req ? RSP_DATA : (tag_hit ? hit_code(ln_q) : RSP_RETRY);
                rdata_q    <= (rd_req && tag_hit && ln_q == LN_READY) ? store_rd : '0;
            end
            if (launch) begin
                ln_q   <= LN_FILL;
                tag_q  <= up_addr[ADDR_W-1:OFF_W];
                kill_q <= 1'b0;
            end else if (ln_q == LN_FILL) begin
                if (done) begin
                    ln_q <= (kill_q || (wr_req && tag_hit)) ? LN_EMPTY
                          : (done_err ? LN_FAIL : LN_READY);
                end else if (wr_req && tag_hit) begin
                    kill_q <= 1'b1;
                end
            end else if (wr_req && tag_hit) begin
                ln_q <= LN_EMPTY;
            end else if (rd_req && tag_hit && ln_q == LN_FAIL) begin
                ln_q <= LN_EMPTY;
            end
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_status = rsp_q.code;
    assign rsp_data   = rdata_q;

    // R3: each accepted request is answered in the next cycle
    p_rsp_next_r3: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> rsp_valid);
    p_rsp_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> !rsp_valid);

    // R5: read to the filling line gets retry
    p_fill_retry_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && tag_hit && ln_q == LN_FILL) |=> (rsp_status == 2'd1));

    // R9: read to a poisoned line gets the error status
    p_fail_error_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_req && tag_hit && ln_q == LN_FAIL) |=> (rsp_status == 2'd2));

    // R8: write hit on a complete line empties it
    p_write_kill_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && tag_hit && ln_q == LN_READY) |=> (ln_q == LN_EMPTY));
endmodule

// File: tb/prefetch_read_bridge_test.sv
`timescale 1ns/1ps
module prefetch_read_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_valid = 1'b0, up_write = 1'b0;
    logic [31:0] up_addr = '0;
    logic        up_ready, rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_data;
    logic        dn_avalid, dn_dready;
    logic        dn_aready = 1'b0, dn_dvalid = 1'b0, dn_err = 1'b0;
    logic [31:0] dn_addr, dn_data = '0;

    int checks = 0, fails = 0;
    int addr_phases = 0, fills = 0;
    bit inject_err = 1'b0;
    int err_beat = 3;
    logic [31:0] last_base = '0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prefetch_read_bridge uut (
        .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
        .up_write(up_write), .up_addr(up_addr), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_data(rsp_data), .dn_avalid(dn_avalid),
        .dn_aready(dn_aready), .dn_addr(dn_addr), .dn_dvalid(dn_dvalid),
        .dn_dready(dn_dready), .dn_data(dn_data), .dn_err(dn_err)
    );

    function automatic logic [31:0] model(logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // downstream slave model
    initial begin
        forever begin
            @(negedge clk);
            if (dn_avalid && !rst) begin
                @(negedge clk);
                dn_aready = 1'b1;
                last_base = dn_addr;
                @(negedge clk);
                dn_aready = 1'b0;
                addr_phases++;
                check(last_base[4:0] == 5'd0, "R4 aligned base", last_base, {last_base[31:5], 5'd0});
                for (int i = 0; i < 8; i++) begin
                    if (i % 3 == 1) @(negedge clk);
                    check(dn_dready == 1'b1, "R4 dready during burst", 32'(dn_dready), 32'd1);
                    dn_dvalid = 1'b1;
                    dn_data   = model(last_base + 32'(4 * i));
                    dn_err    = inject_err && (i == err_beat);
                    @(negedge clk);
                    dn_dvalid = 1'b0;
                    dn_err    = 1'b0;
                end
                inject_err = 1'b0;
                fills++;
            end
        end
    end

    task automatic req(input logic wr, input logic [31:0] a,
                       output logic [1:0] st, output logic [31:0] d);
        @(negedge clk);
        up_valid = 1'b1; up_write = wr; up_addr = a;
        @(posedge clk); #1;
        check(rsp_valid == 1'b1, "R3 response next cycle", 32'(rsp_valid), 32'd1);
        st = rsp_status; d = rsp_data;
        @(negedge clk);
        up_valid = 1'b0; up_write = 1'b0;
    endtask

    task automatic wait_fill();
        int f0 = fills;
        while (fills == f0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_rd(logic [31:0] a, logic [1:0] exp_st, string tag);
        logic [1:0] st; logic [31:0] d;
        req(1'b0, a, st, d);
        check(st == exp_st, tag, 32'(st), 32'(exp_st));
        if (exp_st == 2'd0) check(d == model(a), {tag, " data"}, d, model(a));
    endtask

    task automatic t_reset();
        check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
        check(dn_avalid == 1'b0, "R1 no downstream request", 32'(dn_avalid), 0);
        check(up_ready == 1'b1, "R1 ready high", 32'(up_ready), 1);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R3 quiet when idle", 32'(rsp_valid), 0);
    endtask

    task automatic t_miss_fill_hit();
        int p0 = addr_phases;
        expect_rd(32'h1000_0107, 2'd1, "R2 first read misses");
        expect_rd(32'h1000_0107, 2'd1, "R5 retry while filling");
        expect_rd(32'h1000_011C, 2'd1, "R5 retry other word while filling");
        wait_fill();
        check(addr_phases == p0 + 1, "R2 one burst", 32'(addr_phases - p0), 1);
        check(last_base == 32'h1000_0100, "R4 burst base", last_base, 32'h1000_0100);
        for (int i = 0; i < 8; i++)
            expect_rd(32'h1000_0100 + 32'(4 * i) + 32'(i % 4), 2'd0, "R6 hit word");
        repeat (4) @(negedge clk);
        check(addr_phases == p0 + 1, "R6 no downstream on hits", 32'(addr_phases - p0), 1);
    endtask

    task automatic t_miss_during_fill();
        int p0 = addr_phases;
        expect_rd(32'h2000_0000, 2'd1, "R2 miss B");
        expect_rd(32'h3000_0040, 2'd1, "R7 miss C during fill");
        wait_fill();
        repeat (4) @(negedge clk);
        check(addr_phases == p0 + 1, "R7 no burst for C", 32'(addr_phases - p0), 1);
        expect_rd(32'h2000_0014, 2'd0, "R6 hit B");
        expect_rd(32'h3000_0040, 2'd1, "R7 C retried starts burst");
        wait_fill();
        check(last_base == 32'h3000_0040, "R7 C burst base", last_base, 32'h3000_0040);
        expect_rd(32'h3000_0058, 2'd0, "R6 hit C");
        expect_rd(32'h2000_0014, 2'd1, "R10 B replaced");
        wait_fill();
    endtask

    task automatic t_write_inval();
        logic [1:0] st; logic [31:0] d; int p0;
        // line B is now buffered
        req(1'b1, 32'h5000_0000, st, d);
        check(st == 2'd0, "R8 write outside done", 32'(st), 0);
        expect_rd(32'h2000_0004, 2'd0, "R8 outside write no effect");
        req(1'b1, 32'h2000_0008, st, d);
        check(st == 2'd0, "R8 write inside done", 32'(st), 0);
        p0 = addr_phases;
        expect_rd(32'h2000_0004, 2'd1, "R8 invalidated line misses");
        wait_fill();
        check(addr_phases == p0 + 1, "R8 refetch burst", 32'(addr_phases - p0), 1);
        expect_rd(32'h2000_0004, 2'd0, "R8 refetched hit");
        expect_rd(32'h4000_0020, 2'd1, "R8 miss D");
        req(1'b1, 32'h4000_0030, st, d);
        wait_fill();
        expect_rd(32'h4000_0020, 2'd1, "R8 write during fill discards");
        wait_fill();
        expect_rd(32'h4000_0024, 2'd0, "R8 D after refetch");
    endtask

    task automatic t_error();
        int p0;
        inject_err = 1'b1; err_beat = 3;
        expect_rd(32'h6000_0080, 2'd1, "R9 miss E");
        wait_fill();
        expect_rd(32'h6000_0084, 2'd2, "R9 error reported");
        p0 = addr_phases;
        expect_rd(32'h6000_0084, 2'd1, "R9 after error refetch");
        wait_fill();
        check(addr_phases == p0 + 1, "R9 new burst", 32'(addr_phases - p0), 1);
        expect_rd(32'h6000_0084, 2'd0, "R9 clean data after refetch");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_miss_fill_hit();
        t_miss_during_fill();
        t_write_inval();
        t_error();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule